// File: doc/BRIEF.md
# Pipeline Forwarding and Hazard Control

This block holds the hazard decisions for a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). It compares source register numbers of the instructions in decode and execute against the destination registers still in flight. From those comparisons it picks the operand source for both ALU inputs. It also detects a load whose result is needed by the very next instruction. Finally, it turns a branch resolved as taken in decode into a flush of the instruction fetched behind it.

All outputs are combinational functions of the current pipeline-register contents. The surrounding pipeline uses them in the same cycle. The ALU operand multiplexers take the two forwarding selects. The PC and the fetch/decode register take the hold signal. The decode/execute register takes the bubble signal, which clears its control fields. The fetch/decode register takes the flush signal. Two decode-side bypass flags show when a register that write-back is writing this cycle is also being read in decode. This models a register file that writes in the first half of the cycle and reads in the second half.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: When an execute-stage source register equals the memory-stage destination, that destination is nonzero and its write enable is set, the operand select for that source is 2'b10 (take the memory-stage result).
- R2: When there is no memory-stage match but the source equals the write-back destination, that destination is nonzero and its write enable is set, the select is 2'b01 (take the write-back result).
- R3: When both the memory stage and the write-back stage match the same source, the memory stage wins and the select is 2'b10.
- R4: A destination register of 0, or one whose write enable is clear, never causes forwarding, a decode bypass or a stall. With no valid match, the select is 2'b00 (register file value).
- R5: When the execute stage holds a load (memory-read flag set) whose nonzero destination equals either decode source, the outputs pc_hold, ifid_hold and idex_bubble are all 1 in that cycle.
- R6: When the execute-stage instruction is not a load, no stall is raised, whatever its destination is.
- R7: id_byp_a (id_byp_b) is 1 exactly when write-back writes a nonzero register equal to the first (second) decode source.
- R8: A branch resolved taken in decode raises ifid_flush, so exactly one fetched instruction becomes a bubble. A branch that is not taken raises no flush.
- R9: When a load-use stall and a taken branch occur in the same cycle, the stall wins and ifid_flush stays 0, because the branch is held in decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | REG_W | First source register of the decode instruction |
| id_rs2 | input | REG_W | Second source register of the decode instruction |
| id_br_taken | input | 1 | Decode-stage branch resolved as taken |
| ex_rs1 | input | REG_W | First source register of the execute instruction |
| ex_rs2 | input | REG_W | Second source register of the execute instruction |
| ex_rd | input | REG_W | Destination register of the execute instruction |
| ex_mem_read | input | 1 | Execute instruction is a load |
| mem_rd | input | REG_W | Destination register in the memory stage |
| mem_we | input | 1 | Memory-stage register write enable |
| wb_rd | input | REG_W | Destination register in the write-back stage |
| wb_we | input | 1 | Write-back register write enable |
| fwd_a | output | 2 | Operand A source select (00 file, 10 memory stage, 01 write-back) |
| fwd_b | output | 2 | Operand B source select, same encoding |
| id_byp_a | output | 1 | Decode source 1 is read from the same-cycle write-back |
| id_byp_b | output | 1 | Decode source 2 is read from the same-cycle write-back |
| pc_hold | output | 1 | Keep the PC unchanged this cycle |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| idex_bubble | output | 1 | Clear the control fields entering execute |
| ifid_flush | output | 1 | Turn the fetched instruction into a bubble |

## Verification
The forwarding selects are swept over every combination of source, memory-stage and write-back destinations and write enables drawn from four register numbers, including register 0. This covers single matches, double matches where priority matters, and matches that a cleared enable or a zero register must suppress. The stall and flush outputs are swept over decode sources, execute destination, the load flag and the branch outcome. That separates true load-use cases from non-load producers and from a branch that collides with a stall. The decode bypass flags are swept against write-back destination and enable, so an off-by-one register compare or a missing enable term shows up.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_WB  = 2'b01,
    SRC_MEM = 2'b10
  } opnd_src_e;
endpackage

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_we,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_we,
  output logic [1:0]       sel
);
  import hz_pkg::*;
  logic mem_hit, wb_hit;

  always_comb begin
    mem_hit = mem_we && (mem_rd != '0) && (mem_rd == src);
    wb_hit  = wb_we  && (wb_rd  != '0) && (wb_rd  == src);
    // newer result in the memory stage takes precedence
    if (mem_hit)     sel = SRC_MEM;
    else if (wb_hit) sel = SRC_WB;
    else             sel = SRC_RF;
  end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][REG_W-1:0] id_src,
  input  logic [REG_W-1:0]              ex_rd,
  input  logic                          ex_mem_read,
  output logic                          stall
);
  logic [NUM_SRC-1:0] hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
    assign hit[g] = (id_src[g] == ex_rd);
  end

  always_comb begin
    stall = ex_mem_read && (ex_rd != '0) && (|hit);
  end
endmodule

// File: rtl/hz_redirect.sv
module hz_redirect (
  input  logic br_taken,
  input  logic stall,
  output logic flush
);
  // a stalled branch stays in decode; it redirects once released
  always_comb begin
    flush = br_taken && !stall;
  end
endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] id_rs1,
  input  logic [REG_W-1:0] id_rs2,
  input  logic             id_br_taken,
  input  logic [REG_W-1:0] ex_rs1,
  input  logic [REG_W-1:0] ex_rs2,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_mem_read,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_we,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_we,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic             id_byp_a,
  output logic             id_byp_b,
  output logic             pc_hold,
  output logic             ifid_hold,
  output logic             idex_bubble,
  output logic             ifid_flush
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][REG_W-1:0] ex_src;
  logic [NSRC-1:0][REG_W-1:0] id_src;
  logic [NSRC-1:0][1:0]       sel;
  logic [NSRC-1:0]            byp;
  logic                       lu_stall;

  assign ex_src = {ex_rs2, ex_rs1};
  assign id_src = {id_rs2, id_rs1};

  for (genvar g = 0; g < NSRC; g++) begin : g_opnd
    hz_fwd_sel #(.REG_W(REG_W)) u_sel (
      .src    (ex_src[g]),
      .mem_rd (mem_rd),
      .mem_we (mem_we),
      .wb_rd  (wb_rd),
      .wb_we  (wb_we),
      .sel    (sel[g])
    );
    // register file writes early, reads late: same-cycle bypass in decode
    assign byp[g] = wb_we && (wb_rd != '0) && (wb_rd == id_src[g]);
  end

  hz_load_use #(.REG_W(REG_W), .NUM_SRC(NSRC)) u_lu (
    .id_src      (id_src),
    .ex_rd       (ex_rd),
    .ex_mem_read (ex_mem_read),
    .stall       (lu_stall)
  );

  hz_redirect u_redir (
    .br_taken (id_br_taken),
    .stall    (lu_stall),
    .flush    (ifid_flush)
  );

  assign fwd_a       = sel[0];
  assign fwd_b       = sel[1];
  assign id_byp_a    = byp[0];
  assign id_byp_b    = byp[1];
  assign pc_hold     = lu_stall;
  assign ifid_hold   = lu_stall;
  assign idex_bubble = lu_stall;
endmodule

// File: rtl/hz_checker.sv
module hz_checker #(
  parameter int REG_W = 5
) (
  input logic [REG_W-1:0] id_rs1,
  input logic [REG_W-1:0] id_rs2,
  input logic             id_br_taken,
  input logic [REG_W-1:0] ex_rs1,
  input logic [REG_W-1:0] ex_rd,
  input logic             ex_mem_read,
  input logic [REG_W-1:0] mem_rd,
  input logic             mem_we,
  input logic [REG_W-1:0] wb_rd,
  input logic             wb_we,
  input logic [1:0]       fwd_a,
  input logic             id_byp_a,
  input logic             pc_hold,
  input logic             ifid_hold,
  input logic             idex_bubble,
  input logic             ifid_flush
);
  always_comb begin
    if (fwd_a == 2'b10)
      AST_FWD_MEM_VALID: assert (mem_we && mem_rd != '0 && mem_rd == ex_rs1); // R1
    if (fwd_a == 2'b01)
      AST_FWD_WB_VALID: assert (wb_we && wb_rd != '0 && wb_rd == ex_rs1); // R2
    if (mem_we && mem_rd != '0 && mem_rd == ex_rs1)
      AST_MEM_PRIORITY: assert (fwd_a == 2'b10); // R3
    AST_NO_FWD_ENC: assert (fwd_a != 2'b11); // R4
    if (pc_hold)
      AST_STALL_NEEDS_LOAD: assert (ex_mem_read && ex_rd != '0 &&
                                    (ex_rd == id_rs1 || ex_rd == id_rs2)); // R5
    AST_STALL_AGREE: assert (pc_hold == ifid_hold && ifid_hold == idex_bubble); // R5
    if (!ex_mem_read)
      AST_NO_STALL_ALU: assert (!pc_hold); // R6
    if (id_byp_a)
      AST_BYP_VALID: assert (wb_we && wb_rd == id_rs1); // R7
    if (ifid_flush)
      AST_FLUSH_TAKEN: assert (id_br_taken); // R8
    AST_STALL_BLOCKS_FLUSH: assert (!(ifid_flush && idex_bubble)); // R9
  end
endmodule

bind pipe_hazard_ctl hz_checker #(.REG_W(REG_W)) u_hz_chk (
  .id_rs1      (id_rs1),
  .id_rs2      (id_rs2),
  .id_br_taken (id_br_taken),
  .ex_rs1      (ex_rs1),
  .ex_rd       (ex_rd),
  .ex_mem_read (ex_mem_read),
  .mem_rd      (mem_rd),
  .mem_we      (mem_we),
  .wb_rd       (wb_rd),
  .wb_we       (wb_we),
  .fwd_a       (fwd_a),
  .id_byp_a    (id_byp_a),
  .pc_hold     (pc_hold),
  .ifid_hold   (ifid_hold),
  .idex_bubble (idex_bubble),
  .ifid_flush  (ifid_flush)
);

// File: tb/tb_pipe_hazard_ctl.sv
module tb_pipe_hazard_ctl;
  localparam int RW = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [RW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic id_br_taken, ex_mem_read, mem_we, wb_we;
  logic [1:0] fwd_a, fwd_b;
  logic id_byp_a, id_byp_b, pc_hold, ifid_hold, idex_bubble, ifid_flush;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  pipe_hazard_ctl #(.REG_W(RW)) dut (
    .id_rs1(id_rs1), .id_rs2(id_rs2), .id_br_taken(id_br_taken),
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_mem_read(ex_mem_read),
    .mem_rd(mem_rd), .mem_we(mem_we), .wb_rd(wb_rd), .wb_we(wb_we),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .id_byp_a(id_byp_a), .id_byp_b(id_byp_b),
    .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble),
    .ifid_flush(ifid_flush)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_sel(input int s, input int mr, input int mw,
                                 input int wr, input int ww);
    if (mw != 0 && mr != 0 && mr == s) return 2;
    if (ww != 0 && wr != 0 && wr == s) return 1;
    return 0;
  endfunction

  function automatic string sel_req(input int s, input int mr, input int mw,
                                    input int wr, input int ww);
    bit mh = (mr == s) && mw != 0 && mr != 0;
    bit wh = (wr == s) && ww != 0 && wr != 0;
    if (mh && wh) return "R3";
    if (mh) return "R1";
    if (wh) return "R2";
    return "R4";
  endfunction

  task automatic idle();
    id_rs1 = '0; id_rs2 = '0; id_br_taken = 1'b0;
    ex_rs1 = '0; ex_rs2 = '0; ex_rd = '0; ex_mem_read = 1'b0;
    mem_rd = '0; mem_we = 1'b0; wb_rd = '0; wb_we = 1'b0;
  endtask

  initial begin
    idle();
    @(negedge clk); #1;
    chk("R4 idle fwd_a", fwd_a, 0);
    chk("R4 idle fwd_b", fwd_b, 0);
    chk("R6 idle hold", pc_hold, 0);
    chk("R8 idle flush", ifid_flush, 0);

    // forwarding sweep over four register numbers including 0
    for (int s1 = 0; s1 < 4; s1++)
      for (int s2 = 0; s2 < 4; s2++)
        for (int mr = 0; mr < 4; mr++)
          for (int mw = 0; mw < 2; mw++)
            for (int wr = 0; wr < 4; wr++)
              for (int ww = 0; ww < 2; ww++) begin
                @(negedge clk);
                ex_rs1 = RW'(s1); ex_rs2 = RW'(s2);
                mem_rd = RW'(mr); mem_we = mw[0];
                wb_rd = RW'(wr); wb_we = ww[0];
                #1;
                chk(sel_req(s1, mr, mw, wr, ww), fwd_a, exp_sel(s1, mr, mw, wr, ww));
                chk(sel_req(s2, mr, mw, wr, ww), fwd_b, exp_sel(s2, mr, mw, wr, ww));
              end
    idle();

    // stall / flush / decode-bypass sweep
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int rd = 0; rd < 4; rd++)
          for (int ld = 0; ld < 2; ld++)
            for (int br = 0; br < 2; br++) begin
              bit st;
              @(negedge clk);
              id_rs1 = RW'(a); id_rs2 = RW'(b);
              ex_rd = RW'(rd); ex_mem_read = ld[0]; id_br_taken = br[0];
              wb_rd = RW'(rd); wb_we = ld[0];
              #1;
              st = (ld != 0) && (rd != 0) && (rd == a || rd == b);
              if (ld != 0) chk("R5 pc_hold", pc_hold, int'(st));
              else         chk("R6 pc_hold", pc_hold, 0);
              chk("R5 ifid_hold", ifid_hold, int'(st));
              chk("R5 idex_bubble", idex_bubble, int'(st));
              if (st) chk("R9 flush under stall", ifid_flush, 0);
              else    chk("R8 flush", ifid_flush, br);
              chk("R7 byp_a", id_byp_a, int'(ld != 0 && rd != 0 && rd == a));
              chk("R7 byp_b", id_byp_b, int'(ld != 0 && rd != 0 && rd == b));
            end

    // full-width register numbers, top register
    idle();
    @(negedge clk);
    ex_rs1 = '1; mem_rd = '1; mem_we = 1'b1; wb_rd = '1; wb_we = 1'b1;
    #1;
    chk("R3 top reg priority", fwd_a, 2);
    chk("R4 unmatched b", fwd_b, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule